// File: doc/BRIEF.md
# Byte-Lane Access Permission Guard

This block sits in front of one 32-bit GPIO data port and decides, one byte lane at a time, whether a register access may go through. Each requester presents a privilege flag and a security flag with every access. These two flags place the requester in one of three rights classes: user nonsecure, user secure or privileged secure. An attribute register inside the guard holds one attribute byte per lane. Bits 2:0 of that byte carry a graded permission code from 0 (open to all) to 7 (closed to all). Bit 7 of the byte is a bypass flag, so writing 0x80 into every lane turns checking off completely.

An access to the data port is passed to the target only if every enabled byte lane grants the needed right. If any enabled lane refuses, the access comes back with an error. In that case the target is never strobed and the read data is zero. The attribute register is the second address of the guard. Any requester may read it, but only a privileged secure requester may write it. Each request is taken in a single cycle, and its response appears on the next cycle.

Top module: `gpio_byte_guard`

## Requirements
- R1: After reset, rsp_valid and rsp_err are 0 and rsp_rdata is zero. A full read of the attribute register then returns RESET_ATTR (all zero by default).
- R2: Each cycle with req_valid high produces rsp_valid high on the next cycle. A cycle without a request produces rsp_valid low on the next cycle.
- R3: Permission codes grant read (R), write (W) or no access (N) to the three classes, given as user nonsecure / user secure / privileged secure. Code 0 gives RW/RW/RW. Code 1 gives R/RW/RW. Code 2 gives N/RW/RW. Code 3 gives R/R/RW. Code 4 gives N/R/RW. Code 5 gives N/N/RW. Code 6 gives N/N/R. Code 7 gives N/N/N.
- R4: The class follows from the two flags. A request with req_secure=0 is user nonsecure, whatever req_priv says. A request with req_secure=1 and req_priv=0 is user secure. A request with req_secure=1 and req_priv=1 is privileged secure.
- R5: Lanes are little-endian: attribute byte k (attribute register bits 8k+7:8k) governs data bits 8k+7:8k. Only lanes whose req_be bit is set are checked. An access with no byte enables set passes.
- R6: If any enabled lane fails its check, rsp_err is 1 and rsp_rdata is zero. A failing write strobes no target byte, so the data port is unchanged.
- R7: When bit 7 of an attribute byte is set, that lane passes for every requester and both directions, whatever its code bits hold.
- R8: Only a privileged secure requester may write the attribute register, and the write updates only the enabled bytes. A write from any other requester sets rsp_err and leaves the register unchanged. Reads of the attribute register never fail.
- R9: A successful read returns the enabled bytes (from the target or from the attribute register) and zero in the disabled bytes. Every write returns zero data.
- R10: tgt_wr and tgt_rd pulse only in the request cycle of a passing data-port access. They never pulse for an attribute-register access or a failing one. tgt_be and tgt_wdata carry the request's byte enables and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel_ctl | input | 1 | 1 = attribute register, 0 = data port |
| req_be | input | LANES (4) | Byte enables, bit k = lane k |
| req_wdata | input | LANES*LANE_W (32) | Write data |
| req_priv | input | 1 | Requester is privileged |
| req_secure | input | 1 | Requester is secure |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Access refused |
| rsp_rdata | output | LANES*LANE_W (32) | Read data |
| tgt_wr | output | 1 | Write strobe to the data port |
| tgt_rd | output | 1 | Read strobe to the data port |
| tgt_be | output | LANES (4) | Byte enables to the data port |
| tgt_wdata | output | LANES*LANE_W (32) | Write data to the data port |
| tgt_rdata | input | LANES*LANE_W (32) | Current data port contents |

## Verification
The bench builds the guard with its default parameters: four 8-bit lanes, 3-bit codes, the bypass flag enabled and an all-open reset value. With these values the stimulus can cover all sixteen byte-enable patterns, every code against every pair of privilege and security flags, and the bypass flag on top of any code. Directed sweeps go through each code for all four flag combinations in both directions. After that, mixed per-lane codes and randomised traffic look for cross-lane masking errors and attribute-register guard errors.

// File: rtl/gbg_pkg.sv
package gbg_pkg;

   typedef enum logic [1:0] {
      CLS_USER_NS = 2'd0,
      CLS_USER_S  = 2'd1,
      CLS_PRIV_S  = 2'd2
   } req_class_e;

   typedef struct packed {
      logic rd;
      logic wr;
   } perm_t;

   // Graded table: each class loses rights at its own thresholds.
   function automatic perm_t perm_lookup(input logic [2:0] code, input req_class_e cls);
      perm_t p;
      p = '0;
      unique case (cls)
         CLS_PRIV_S: begin
            p.rd = (code <= 3'd6);
            p.wr = (code <= 3'd5);
         end
         CLS_USER_S: begin
            p.rd = (code <= 3'd4);
            p.wr = (code <= 3'd2);
         end
         default: begin
            p.rd = (code == 3'd0) || (code == 3'd1) || (code == 3'd3);
            p.wr = (code == 3'd0);
         end
      endcase
      return p;
   endfunction

endpackage

// File: rtl/gbg_class_decode.sv
module gbg_class_decode
   import gbg_pkg::*;
(
   input  logic       priv,
   input  logic       secure,
   output req_class_e cls
);
   always_comb begin
      if (!secure)   cls = CLS_USER_NS;
      else if (priv) cls = CLS_PRIV_S;
      else           cls = CLS_USER_S;
   end
endmodule

// File: rtl/gbg_attr_reg.sv
module gbg_attr_reg #(
   parameter int                     LANES     = 4,
   parameter int                     LANE_W    = 8,
   parameter logic [LANES*LANE_W-1:0] RESET_VAL = '0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [LANES-1:0]        be,
   input  logic [LANES*LANE_W-1:0] wdata,
   output logic [LANES*LANE_W-1:0] q
);
   for (genvar k = 0; k < LANES; k++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q[k*LANE_W +: LANE_W] <= RESET_VAL[k*LANE_W +: LANE_W];
         else if (wr_en && be[k])
            q[k*LANE_W +: LANE_W] <= wdata[k*LANE_W +: LANE_W];
      end
   end
endmodule

// File: rtl/gbg_lane_check.sv
module gbg_lane_check
   import gbg_pkg::*;
#(
   parameter int CODE_W    = 3,
   parameter bit BYPASS_EN = 1'b1
) (
   input  logic [CODE_W-1:0] code,
   input  logic              bypass,
   input  req_class_e        cls,
   input  logic              is_write,
   input  logic              lane_en,
   output logic              lane_fail
);
   perm_t perm;
   logic  byp_eff;
   logic  granted;

   if (BYPASS_EN) begin : g_byp
      assign byp_eff = bypass;
   end else begin : g_nobyp
      assign byp_eff = 1'b0;
   end

   assign perm      = perm_lookup(code, cls);
   assign granted   = is_write ? perm.wr : perm.rd;
   assign lane_fail = lane_en & ~byp_eff & ~granted;
endmodule

// File: rtl/gpio_byte_guard.sv
module gpio_byte_guard
   import gbg_pkg::*;
#(
   parameter int                      LANES      = 4,
   parameter int                      LANE_W     = 8,
   parameter int                      CODE_W     = 3,
   parameter int                      BYPASS_BIT = 7,
   parameter bit                      BYPASS_EN  = 1'b1,
   parameter logic [LANES*LANE_W-1:0] RESET_ATTR = '0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   input  logic                    req_write,
   input  logic                    req_sel_ctl,
   input  logic [LANES-1:0]        req_be,
   input  logic [LANES*LANE_W-1:0] req_wdata,
   input  logic                    req_priv,
   input  logic                    req_secure,
   output logic                    rsp_valid,
   output logic                    rsp_err,
   output logic [LANES*LANE_W-1:0] rsp_rdata,
   output logic                    tgt_wr,
   output logic                    tgt_rd,
   output logic [LANES-1:0]        tgt_be,
   output logic [LANES*LANE_W-1:0] tgt_wdata,
   input  logic [LANES*LANE_W-1:0] tgt_rdata
);
   localparam int DATA_W = LANES * LANE_W;

   if (CODE_W != 3) begin : g_bad_code_w
      $error("gpio_byte_guard: CODE_W must be 3 for the graded table");
   end
   if (BYPASS_BIT < CODE_W || BYPASS_BIT >= LANE_W) begin : g_bad_byp_bit
      $error("gpio_byte_guard: BYPASS_BIT must lie above the code field inside a lane");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("gpio_byte_guard: LANES must be at least 1");
   end

   req_class_e         cls;
   logic [DATA_W-1:0]  attr_q;
   logic [LANES-1:0]   fail_vec;
   logic [DATA_W-1:0]  be_mask;
   logic               data_fail;
   logic               ctl_wr_ok;
   logic               ctl_wr_deny;
   logic               data_go;
   logic               nxt_err;
   logic [DATA_W-1:0]  nxt_rdata;

   gbg_class_decode u_cls (
      .priv   (req_priv),
      .secure (req_secure),
      .cls    (cls)
   );

   assign ctl_wr_ok   = req_valid & req_sel_ctl & req_write & (cls == CLS_PRIV_S);
   assign ctl_wr_deny = req_valid & req_sel_ctl & req_write & (cls != CLS_PRIV_S);

   gbg_attr_reg #(
      .LANES     (LANES),
      .LANE_W    (LANE_W),
      .RESET_VAL (RESET_ATTR)
   ) u_attr (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (ctl_wr_ok),
      .be    (req_be),
      .wdata (req_wdata),
      .q     (attr_q)
   );

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      gbg_lane_check #(
         .CODE_W    (CODE_W),
         .BYPASS_EN (BYPASS_EN)
      ) u_chk (
         .code      (attr_q[k*LANE_W +: CODE_W]),
         .bypass    (attr_q[k*LANE_W + BYPASS_BIT]),
         .cls       (cls),
         .is_write  (req_write),
         .lane_en   (req_be[k]),
         .lane_fail (fail_vec[k])
      );
      assign be_mask[k*LANE_W +: LANE_W] = {LANE_W{req_be[k]}};
   end

   assign data_fail = |fail_vec;
   assign data_go   = req_valid & ~req_sel_ctl & ~data_fail;

   assign tgt_wr    = data_go & req_write;
   assign tgt_rd    = data_go & ~req_write;
   assign tgt_be    = req_be;
   assign tgt_wdata = req_wdata;

   always_comb begin
      nxt_err = req_sel_ctl ? ctl_wr_deny : data_fail;
      if (req_write || nxt_err)
         nxt_rdata = '0;
      else if (req_sel_ctl)
         nxt_rdata = attr_q & be_mask;
      else
         nxt_rdata = tgt_rdata & be_mask;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_err   <= req_valid & nxt_err;
         rsp_rdata <= req_valid ? nxt_rdata : '0;
      end
   end
endmodule

// File: rtl/gbg_checker.sv
module gbg_checker #(
   parameter int LANES  = 4,
   parameter int LANE_W = 8
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    req_valid,
   input logic                    req_write,
   input logic                    req_sel_ctl,
   input logic [LANES-1:0]        req_be,
   input logic [LANES*LANE_W-1:0] req_wdata,
   input logic                    req_priv,
   input logic                    req_secure,
   input logic                    rsp_valid,
   input logic                    rsp_err,
   input logic [LANES*LANE_W-1:0] rsp_rdata,
   input logic                    tgt_wr,
   input logic                    tgt_rd,
   input logic [LANES-1:0]        tgt_be,
   input logic [LANES*LANE_W-1:0] tgt_wdata,
   input logic [LANES*LANE_W-1:0] tgt_rdata
);
   a_r2_rsp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   a_r2_no_rsp_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   a_r6_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_err) |-> (rsp_rdata == '0));

   a_r6_strobe_means_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_wr || tgt_rd) |=> (rsp_valid && !rsp_err));

   a_r8_ctl_write_guard: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_sel_ctl && req_write && !(req_priv && req_secure)) |=> rsp_err);

   a_r9_write_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write) |=> (rsp_rdata == '0));

   a_r10_ctl_no_target: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_sel_ctl) |-> !(tgt_wr || tgt_rd));

   a_r10_target_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> !(tgt_wr || tgt_rd));

   a_r10_target_passthru: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_wr |-> (tgt_be == req_be && tgt_wdata == req_wdata));
endmodule

bind gpio_byte_guard gbg_checker #(.LANES(LANES), .LANE_W(LANE_W)) u_gbg_chk (.*);

// File: tb/gpio_byte_guard_tb.sv
module gpio_byte_guard_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_sel_ctl = 1'b0;
   logic [3:0]  req_be = '0;
   logic [31:0] req_wdata = '0;
   logic        req_priv = 1'b0, req_secure = 1'b0;
   logic        rsp_valid, rsp_err, tgt_wr, tgt_rd;
   logic [31:0] rsp_rdata, tgt_wdata;
   logic [3:0]  tgt_be;
   logic [31:0] tgt_mem = 32'h0;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;
   logic [31:0] m_attr = 32'h0;
   logic [31:0] m_mem  = 32'h0;

   always #2 clk = ~clk;

   gpio_byte_guard u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_sel_ctl(req_sel_ctl), .req_be(req_be), .req_wdata(req_wdata),
      .req_priv(req_priv), .req_secure(req_secure), .rsp_valid(rsp_valid),
      .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .tgt_wr(tgt_wr), .tgt_rd(tgt_rd),
      .tgt_be(tgt_be), .tgt_wdata(tgt_wdata), .tgt_rdata(tgt_mem)
   );

   always @(posedge clk) begin
      if (tgt_wr)
         for (int k = 0; k < 4; k++)
            if (tgt_be[k]) tgt_mem[k*8 +: 8] <= tgt_wdata[k*8 +: 8];
   end

   // 0 = user nonsecure, 1 = user secure, 2 = privileged secure
   function automatic int f_cls(input logic priv, input logic sec);
      if (!sec) return 0;
      return priv ? 2 : 1;
   endfunction

   // returns {rd, wr}; rights listed per code as {UN, US, PS}
   function automatic logic [1:0] f_rights(input logic [2:0] code, input int cls);
      logic [5:0] row;
      case (code)
         3'd0: row = {2'b11, 2'b11, 2'b11};
         3'd1: row = {2'b10, 2'b11, 2'b11};
         3'd2: row = {2'b00, 2'b11, 2'b11};
         3'd3: row = {2'b10, 2'b10, 2'b11};
         3'd4: row = {2'b00, 2'b10, 2'b11};
         3'd5: row = {2'b00, 2'b00, 2'b11};
         3'd6: row = {2'b00, 2'b00, 2'b10};
         default: row = 6'b0;
      endcase
      return row[(2-cls)*2 +: 2];
   endfunction

   function automatic logic [31:0] f_mask(input logic [3:0] be);
      logic [31:0] m;
      for (int k = 0; k < 4; k++) m[k*8 +: 8] = {8{be[k]}};
      return m;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic access(input string req, input logic sel, input logic wr,
                         input logic [3:0] be, input logic [31:0] wd,
                         input logic priv, input logic sec);
      logic        e_err;
      logic [31:0] e_rd;
      int          c;
      logic [1:0]  rt;
      @(negedge clk);
      req_valid = 1'b1; req_sel_ctl = sel; req_write = wr; req_be = be;
      req_wdata = wd; req_priv = priv; req_secure = sec;
      c = f_cls(priv, sec);
      e_err = 1'b0;
      if (sel) begin
         if (wr && c != 2) e_err = 1'b1;
      end else begin
         for (int k = 0; k < 4; k++) begin
            rt = f_rights(m_attr[k*8 +: 3], c);
            if (be[k] && !m_attr[k*8+7] && !(wr ? rt[0] : rt[1])) e_err = 1'b1;
         end
      end
      e_rd = (wr || e_err) ? 32'h0 : ((sel ? m_attr : m_mem) & f_mask(be));
      @(negedge clk);
      req_valid = 1'b0;
      if (!e_err && wr) begin
         if (sel) m_attr = (m_attr & ~f_mask(be)) | (wd & f_mask(be));
         else     m_mem  = (m_mem  & ~f_mask(be)) | (wd & f_mask(be));
      end
      check({req, " rsp_valid (R2)"}, {31'b0, rsp_valid}, 32'd1);
      check({req, " rsp_err"}, {31'b0, rsp_err}, {31'b0, e_err});
      check({req, " rsp_rdata"}, rsp_rdata, e_rd);
      check({req, " port contents (R6)"}, tgt_mem, m_mem);
   endtask

   task automatic set_attr(input logic [31:0] v);
      access("R8 setup", 1'b1, 1'b1, 4'hF, v, 1'b1, 1'b1);
   endtask

   initial begin
      #800000;
      if (!done) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 rsp_valid in reset", {31'b0, rsp_valid}, 32'd0);
      check("R1 rsp_err in reset", {31'b0, rsp_err}, 32'd0);
      check("R1 rsp_rdata in reset", rsp_rdata, 32'd0);
      rst_n = 1'b1;
      access("R1 attr reset readback", 1'b1, 1'b0, 4'hF, 32'h0, 1'b0, 1'b0);
      @(negedge clk);
      check("R2 idle no response", {31'b0, rsp_valid}, 32'd0);

      // R3/R4 sweep: all lanes same code, all flag combos, both directions
      for (int code = 0; code < 8; code++) begin
         set_attr({4{5'b0, code[2:0]}});
         for (int f = 0; f < 4; f++) begin
            access("R3 R4 write sweep", 1'b0, 1'b1, 4'hF, $urandom, f[1], f[0]);
            access("R3 R4 read sweep", 1'b0, 1'b0, 4'hF, 32'h0, f[1], f[0]);
         end
      end

      // R5 per-lane: lane0 open, lane1 closed, lane2 PS only, lane3 read-only users
      set_attr(32'h03_05_07_00);
      access("R5 lane0 only write", 1'b0, 1'b1, 4'b0001, 32'hA5A5A5A5, 1'b0, 1'b0);
      access("R5 lane1 write denied", 1'b0, 1'b1, 4'b0010, 32'h11111111, 1'b1, 1'b1);
      access("R5 lane2 user denied", 1'b0, 1'b1, 4'b0100, 32'h22222222, 1'b0, 1'b1);
      access("R5 lane2 priv ok", 1'b0, 1'b1, 4'b0100, 32'h33333333, 1'b1, 1'b1);
      access("R5 lane3 read user", 1'b0, 1'b0, 4'b1000, 32'h0, 1'b0, 1'b1);
      access("R5 mixed fail all", 1'b0, 1'b1, 4'b0101, 32'h44444444, 1'b0, 1'b0);
      access("R5 no enables pass", 1'b0, 1'b1, 4'b0000, 32'h55555555, 1'b0, 1'b0);
      access("R9 partial read mask", 1'b0, 1'b0, 4'b0101, 32'h0, 1'b1, 1'b1);

      // R7 bypass
      set_attr(32'h87_87_80_87);
      access("R7 bypass user write", 1'b0, 1'b1, 4'hF, 32'hDEADBEEF, 1'b0, 1'b0);
      access("R7 bypass user read", 1'b0, 1'b0, 4'hF, 32'h0, 1'b1, 1'b0);

      // R8 guard on attribute register
      access("R8 user secure ctl write", 1'b1, 1'b1, 4'hF, 32'h07070707, 1'b0, 1'b1);
      access("R8 priv nonsecure ctl write", 1'b1, 1'b1, 4'hF, 32'h07070707, 1'b1, 1'b0);
      access("R8 readback unchanged", 1'b1, 1'b0, 4'hF, 32'h0, 1'b0, 1'b0);
      access("R8 partial ctl write", 1'b1, 1'b1, 4'b0010, 32'h00000600, 1'b1, 1'b1);
      access("R8 partial readback", 1'b1, 1'b0, 4'hF, 32'h0, 1'b0, 1'b0);

      // random traffic (R3..R10)
      for (int i = 0; i < 600; i++) begin
         logic [31:0] v;
         logic sel;
         for (int k = 0; k < 4; k++)
            v[k*8 +: 8] = {($urandom % 4 == 0), 4'b0, 3'($urandom)};
         sel = ($urandom % 5 == 0);
         access("R10 random", sel, 1'($urandom), 4'($urandom),
                sel ? v : $urandom, 1'($urandom), 1'($urandom));
      end

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule